// File: doc/BRIEF.md
# Bridge Data Poisoning Path

This block carries data words across a bridge between two protection schemes. An upstream link protects each word with a SECDED code, and a downstream bus protects each word with a single parity bit. Each direction passes through a small internal word buffer. The block checks the protection on every word it accepts and checks the buffer's own parity again when the word leaves. It never discards a word. A single-bit code error is corrected, and the word continues clean. Any other error is recorded once in a sticky status register, and the word continues marked as poisoned.

A poisoned word leaving toward the downstream bus carries inverted parity. A poisoned word leaving toward the upstream link carries a check code that is deliberately made uncorrectable. The poison mark travels with the word inside the buffer, so an error that has already been recorded is never recorded a second time. Software reads the status through `err_status` and clears bits by writing ones. Two injection inputs corrupt the word being written into either buffer, which lets the internal-error path be tested.

Top module: `bridge_poison_path`

## Requirements
- R1: While reset is held and right after it is released, `err_status` is zero, both output valids are low and both input readies are high.
- R2: The upstream code is 5 bits. Data bit i sits at Hamming position 3,5,6,7,9,10,11,12 for i = 0..7. Check bit k (k = 0..3) is the XOR of the data bits whose position has bit k set. Bit 4 is the XOR of all 8 data bits and the 4 check bits. When exactly one of the 13 code-word bits is flipped, the word is corrected, leaves downstream with good even parity (parity bit equals the XOR of the data), and sets no status bit.
- R3: When two code-word bits are flipped, status bit 0 is set. The received data bits are forwarded downstream unchanged, with the parity bit inverted.
- R4: A downstream input word whose parity bit differs from the XOR of its data sets status bit 2. It is forwarded upstream with its data and with the correct code XOR 5'b00011.
- R5: A buffer error on a clean word heading downstream sets status bit 1, and writes 3'b111 into status bits 23:21. The word leaves with inverted parity.
- R6: A buffer error on a clean word heading upstream sets status bit 3 and writes 3'b111 into bits 23:21. The word leaves with its code XOR 5'b00011.
- R7: A buffer error on a word that is already poisoned sets no further status bit. The word still leaves poisoned.
- R8: Clean words leave with good parity or the correct code, and set no status bit. Bad parity or a forced code appears only after the matching error has been recorded.
- R9: Status bits stay set until a status write has a one in their position. Zeros in a write have no effect.
- R10: Each buffer holds DEPTH words in arrival order. Input ready goes low only when the buffer is full, and no word is lost or overwritten while the output is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_in_valid | input | 1 | Upstream word valid (toward downstream) |
| up_in_ready | output | 1 | Downstream-direction buffer can accept |
| up_in_data | input | 8 | Upstream data |
| up_in_ecc | input | 5 | Upstream SECDED code |
| dn_out_valid | output | 1 | Word available on downstream bus |
| dn_out_ready | input | 1 | Downstream bus takes the word |
| dn_out_data | output | 8 | Downstream data |
| dn_out_par | output | 1 | Downstream even parity, inverted when poisoned |
| dn_in_valid | input | 1 | Downstream word valid (toward upstream) |
| dn_in_ready | output | 1 | Upstream-direction buffer can accept |
| dn_in_data | input | 8 | Downstream data |
| dn_in_par | input | 1 | Downstream parity |
| up_out_valid | output | 1 | Word available on upstream link |
| up_out_ready | input | 1 | Upstream link takes the word |
| up_out_data | output | 8 | Upstream data |
| up_out_ecc | output | 5 | Upstream code, forced uncorrectable when poisoned |
| inj_dn_buf | input | 1 | Corrupt the word written into the downstream-direction buffer |
| inj_up_buf | input | 1 | Corrupt the word written into the upstream-direction buffer |
| sts_wr_en | input | 1 | Status write strobe |
| sts_wr_data | input | 24 | Status write data, ones clear |
| err_status | output | 24 | Error flags in bits 3:0, failing agent in bits 23:21 |

## Verification
The checks that link corrupted output to a recorded error assume that status bits are not cleared while a poisoned word is still inside a buffer. The stimulus therefore drains each word before it writes to the status register. The injection inputs are assumed to matter only in a cycle where a word is accepted, and the bench raises them only together with a valid input word. The ready checks count handshakes at the ports. They assume the outputs are taken only while valid is high, and the stimulus also obeys this during the stall sequence.

// File: rtl/bpp_pkg.sv
package bpp_pkg;
    localparam int DW     = 8;
    localparam int HW     = 4;
    localparam int CW     = HW + 1;
    localparam int NFLAG  = 4;
    localparam int AGT_LO = 21;
    localparam int AGT_W  = 3;
    localparam int STS_W  = AGT_LO + AGT_W;

    localparam int F_DN_MBE = 0;
    localparam int F_DN_INT = 1;
    localparam int F_UP_PAR = 2;
    localparam int F_UP_INT = 3;

    localparam logic [AGT_W-1:0] AGT_SELF    = '1;
    localparam logic [CW-1:0]    POISON_MASK = CW'(3);

    typedef struct packed {
        logic          poison;
        logic          par;
        logic [DW-1:0] data;
    } buf_word_t;

    // Hamming position of data bit idx: skips positions that are powers of two
    function automatic int unsigned data_pos(int unsigned idx);
        int unsigned res = 0;
        int unsigned n   = 0;
        for (int unsigned q = 3; q < (32'd1 << HW); q++) begin
            if (((q & (q - 1)) != 0) && (res == 0)) begin
                if (n == idx) res = q;
                n++;
            end
        end
        return res;
    endfunction

    function automatic logic [HW-1:0] hamming(logic [DW-1:0] d);
        logic [HW-1:0] h = '0;
        for (int i = 0; i < DW; i++) begin
            int unsigned pos = data_pos(i);
            for (int k = 0; k < HW; k++) begin
                if (pos[k]) h[k] ^= d[i];
            end
        end
        return h;
    endfunction

    function automatic logic [CW-1:0] ecc_encode(logic [DW-1:0] d);
        logic [HW-1:0] h = hamming(d);
        return {(^d) ^ (^h), h};
    endfunction
endpackage

// File: rtl/bpp_ecc_check.sv
module bpp_ecc_check
    import bpp_pkg::*;
(
    input  logic [DW-1:0] data,
    input  logic [CW-1:0] ecc,
    output logic [DW-1:0] data_fix,
    output logic          mbe
);
    logic [HW-1:0] syn;
    logic          ovr;

    always_comb begin
        syn      = hamming(data) ^ ecc[HW-1:0];
        ovr      = ^{data, ecc};
        data_fix = data;
        if (ovr) begin
            for (int i = 0; i < DW; i++) begin
                if (HW'(data_pos(i)) == syn) data_fix[i] = ~data[i];
            end
        end
        mbe = !ovr && (syn != '0);
    end
endmodule

// File: rtl/bpp_word_buf.sv
module bpp_word_buf
    import bpp_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_poison,
    input  logic          wr_inject,
    output logic          full,
    input  logic          rd_en,
    output logic          not_empty,
    output buf_word_t     rd_word
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        buf_word_t [DEPTH-1:0] mem;
        logic [AW-1:0]         wr_ptr;
        logic [AW-1:0]         rd_ptr;
        logic [AW:0]           count;
    } buf_state_t;

    buf_state_t st_d, st_q;
    buf_word_t  entry;
    logic       do_wr, do_rd;

    always_comb begin
        full      = (st_q.count == (AW+1)'(DEPTH));
        not_empty = (st_q.count != '0);
        rd_word   = st_q.mem[st_q.rd_ptr];
        do_wr     = wr_en && !full;
        do_rd     = rd_en && not_empty;

        // parity is taken before the optional corruption so a flip is seen on read
        entry.data   = wr_data ^ DW'(wr_inject);
        entry.par    = ^wr_data;
        entry.poison = wr_poison;

        st_d = st_q;
        if (do_wr) begin
            st_d.mem[st_q.wr_ptr] = entry;
            st_d.wr_ptr           = st_q.wr_ptr + 1'b1;
        end
        if (do_rd) st_d.rd_ptr = st_q.rd_ptr + 1'b1;
        case ({do_wr, do_rd})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/bpp_err_log.sv
module bpp_err_log
    import bpp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set_flags,
    input  logic             set_agent,
    input  logic             clr_en,
    input  logic [NFLAG-1:0] clr_flags,
    input  logic [AGT_W-1:0] clr_agent,
    output logic [NFLAG-1:0] flags_q,
    output logic [AGT_W-1:0] agent_q
);
    typedef struct packed {
        logic [AGT_W-1:0] agent;
        logic [NFLAG-1:0] flags;
    } log_state_t;

    log_state_t log_d, log_q;

    always_comb begin
        log_d = log_q;
        if (clr_en) begin
            log_d.flags = log_q.flags & ~clr_flags;
            log_d.agent = log_q.agent & ~clr_agent;
        end
        // a new error wins over a clear in the same cycle
        log_d.flags = log_d.flags | set_flags;
        if (set_agent) log_d.agent = AGT_SELF;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) log_q <= '0;
        else        log_q <= log_d;
    end

    assign flags_q = log_q.flags;
    assign agent_q = log_q.agent;
endmodule

// File: rtl/bridge_poison_path.sv
module bridge_poison_path
    import bpp_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_in_valid,
    output logic             up_in_ready,
    input  logic [DW-1:0]    up_in_data,
    input  logic [CW-1:0]    up_in_ecc,
    output logic             dn_out_valid,
    input  logic             dn_out_ready,
    output logic [DW-1:0]    dn_out_data,
    output logic             dn_out_par,
    input  logic             dn_in_valid,
    output logic             dn_in_ready,
    input  logic [DW-1:0]    dn_in_data,
    input  logic             dn_in_par,
    output logic             up_out_valid,
    input  logic             up_out_ready,
    output logic [DW-1:0]    up_out_data,
    output logic [CW-1:0]    up_out_ecc,
    input  logic             inj_dn_buf,
    input  logic             inj_up_buf,
    input  logic             sts_wr_en,
    input  logic [STS_W-1:0] sts_wr_data,
    output logic [STS_W-1:0] err_status
);
    logic [DW-1:0]    dn_fix;
    logic             dn_mbe, dn_full, dn_ne, up_full, up_ne;
    buf_word_t        dn_rd, up_rd;
    logic             dn_acc, dn_pop, up_acc, up_pop;
    logic             dn_bad, up_bad, dn_poison, up_poison, up_par_err;
    logic [NFLAG-1:0] set_flags;
    logic [NFLAG-1:0] flags_q;
    logic [AGT_W-1:0] agent_q;
    logic             unused_wr_bits;

    assign unused_wr_bits = ^sts_wr_data[AGT_LO-1:NFLAG];

    bpp_ecc_check u_ecc (
        .data     (up_in_data),
        .ecc      (up_in_ecc),
        .data_fix (dn_fix),
        .mbe      (dn_mbe)
    );

    bpp_word_buf #(.DEPTH(DEPTH)) u_dn_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (up_in_valid),
        .wr_data   (dn_fix),
        .wr_poison (dn_mbe),
        .wr_inject (inj_dn_buf),
        .full      (dn_full),
        .rd_en     (dn_out_ready),
        .not_empty (dn_ne),
        .rd_word   (dn_rd)
    );

    bpp_word_buf #(.DEPTH(DEPTH)) u_up_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (dn_in_valid),
        .wr_data   (dn_in_data),
        .wr_poison (up_par_err),
        .wr_inject (inj_up_buf),
        .full      (up_full),
        .rd_en     (up_out_ready),
        .not_empty (up_ne),
        .rd_word   (up_rd)
    );

    always_comb begin
        up_in_ready = !dn_full;
        dn_in_ready = !up_full;
        dn_acc      = up_in_valid && up_in_ready;
        up_acc      = dn_in_valid && dn_in_ready;
        up_par_err  = (^dn_in_data) != dn_in_par;

        dn_out_valid = dn_ne;
        dn_out_data  = dn_rd.data;
        dn_bad       = (^dn_rd.data) != dn_rd.par;
        dn_poison    = dn_rd.poison || dn_bad;
        dn_out_par   = (^dn_rd.data) ^ dn_poison;
        dn_pop       = dn_out_valid && dn_out_ready;

        up_out_valid = up_ne;
        up_out_data  = up_rd.data;
        up_bad       = (^up_rd.data) != up_rd.par;
        up_poison    = up_rd.poison || up_bad;
        up_out_ecc   = ecc_encode(up_rd.data) ^ (up_poison ? POISON_MASK : '0);
        up_pop       = up_out_valid && up_out_ready;

        set_flags           = '0;
        set_flags[F_DN_MBE] = dn_acc && dn_mbe;
        set_flags[F_DN_INT] = dn_pop && dn_bad && !dn_rd.poison;
        set_flags[F_UP_PAR] = up_acc && up_par_err;
        set_flags[F_UP_INT] = up_pop && up_bad && !up_rd.poison;
    end

    bpp_err_log u_log (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_flags (set_flags),
        .set_agent (set_flags[F_DN_INT] || set_flags[F_UP_INT]),
        .clr_en    (sts_wr_en),
        .clr_flags (sts_wr_data[NFLAG-1:0]),
        .clr_agent (sts_wr_data[AGT_LO +: AGT_W]),
        .flags_q   (flags_q),
        .agent_q   (agent_q)
    );

    always_comb begin
        err_status                   = '0;
        err_status[NFLAG-1:0]        = flags_q;
        err_status[AGT_LO +: AGT_W]  = agent_q;
    end
endmodule

// File: rtl/bpp_checker.sv
module bpp_checker
    import bpp_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             up_in_valid,
    input logic             up_in_ready,
    input logic [DW-1:0]    up_in_data,
    input logic [CW-1:0]    up_in_ecc,
    input logic             dn_out_valid,
    input logic             dn_out_ready,
    input logic [DW-1:0]    dn_out_data,
    input logic             dn_out_par,
    input logic             dn_in_valid,
    input logic             dn_in_ready,
    input logic [DW-1:0]    dn_in_data,
    input logic             dn_in_par,
    input logic             up_out_valid,
    input logic             up_out_ready,
    input logic [DW-1:0]    up_out_data,
    input logic [CW-1:0]    up_out_ecc,
    input logic             clr_en,
    input logic [NFLAG-1:0] clr_lo,
    input logic [NFLAG-1:0] sts_flags,
    input logic [AGT_W-1:0] sts_agent
);
    localparam int CNTW = $clog2(DEPTH) + 1;

    logic [CNTW-1:0]  dn_cnt, up_cnt;
    logic [NFLAG-1:0] keep;
    logic             in_mbe;

    always_comb begin
        keep   = sts_flags & ~(clr_en ? clr_lo : '0);
        in_mbe = !(^{up_in_data, up_in_ecc}) && (hamming(up_in_data) != up_in_ecc[HW-1:0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dn_cnt <= '0;
            up_cnt <= '0;
        end else begin
            dn_cnt <= dn_cnt + CNTW'(up_in_valid && up_in_ready) - CNTW'(dn_out_valid && dn_out_ready);
            up_cnt <= up_cnt + CNTW'(dn_in_valid && dn_in_ready) - CNTW'(up_out_valid && up_out_ready);
        end
    end

    AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sts_flags & $past(keep)) == $past(keep))); // R9

    AST_MBE_LOGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (up_in_valid && up_in_ready && in_mbe) |=> sts_flags[F_DN_MBE]); // R3

    AST_PAR_LOGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_in_valid && dn_in_ready && ((^dn_in_data) != dn_in_par)) |=> sts_flags[F_UP_PAR]); // R4

    AST_DN_BADPAR_LOGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_out_valid && dn_out_ready && ((^dn_out_data) != dn_out_par))
        |=> (sts_flags[F_DN_MBE] || sts_flags[F_DN_INT])); // R8

    AST_UP_BADECC_LOGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (up_out_valid && up_out_ready && (up_out_ecc != ecc_encode(up_out_data)))
        |=> (sts_flags[F_UP_PAR] || sts_flags[F_UP_INT])); // R8

    AST_DN_AGENT_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_flags[F_DN_INT]) |-> (sts_agent == AGT_SELF)); // R5

    AST_UP_AGENT_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_flags[F_UP_INT]) |-> (sts_agent == AGT_SELF)); // R6

    AST_DN_READY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        up_in_ready == (dn_cnt != CNTW'(DEPTH))); // R10

    AST_UP_READY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        dn_in_ready == (up_cnt != CNTW'(DEPTH))); // R10
endmodule

bind bridge_poison_path bpp_checker #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .up_in_valid  (up_in_valid),
    .up_in_ready  (up_in_ready),
    .up_in_data   (up_in_data),
    .up_in_ecc    (up_in_ecc),
    .dn_out_valid (dn_out_valid),
    .dn_out_ready (dn_out_ready),
    .dn_out_data  (dn_out_data),
    .dn_out_par   (dn_out_par),
    .dn_in_valid  (dn_in_valid),
    .dn_in_ready  (dn_in_ready),
    .dn_in_data   (dn_in_data),
    .dn_in_par    (dn_in_par),
    .up_out_valid (up_out_valid),
    .up_out_ready (up_out_ready),
    .up_out_data  (up_out_data),
    .up_out_ecc   (up_out_ecc),
    .clr_en       (sts_wr_en),
    .clr_lo       (sts_wr_data[3:0]),
    .sts_flags    (err_status[3:0]),
    .sts_agent    (err_status[23:21])
);

// File: tb/bridge_poison_path_tb.sv
`timescale 1ns/1ps
module bridge_poison_path_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        up_in_valid = 1'b0, up_in_ready;
    logic [7:0]  up_in_data = '0;
    logic [4:0]  up_in_ecc = '0;
    logic        dn_out_valid, dn_out_ready = 1'b1;
    logic [7:0]  dn_out_data;
    logic        dn_out_par;
    logic        dn_in_valid = 1'b0, dn_in_ready;
    logic [7:0]  dn_in_data = '0;
    logic        dn_in_par = 1'b0;
    logic        up_out_valid, up_out_ready = 1'b1;
    logic [7:0]  up_out_data;
    logic [4:0]  up_out_ecc;
    logic        inj_dn_buf = 1'b0, inj_up_buf = 1'b0;
    logic        sts_wr_en = 1'b0;
    logic [23:0] sts_wr_data = '0;
    logic [23:0] err_status;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    bridge_poison_path #(.DEPTH(4)) dut_i (.*);

    function automatic logic [4:0] ref_ecc(input logic [7:0] d);
        int pos[8] = '{3, 5, 6, 7, 9, 10, 11, 12};
        logic [3:0] h = '0;
        for (int i = 0; i < 8; i++)
            for (int k = 0; k < 4; k++)
                if (((pos[i] >> k) & 1) == 1) h[k] ^= d[i];
        return {(^d) ^ (^h), h};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic write_sts(input logic [23:0] v);
        @(negedge clk);
        sts_wr_en = 1'b1; sts_wr_data = v;
        @(negedge clk);
        sts_wr_en = 1'b0; sts_wr_data = '0;
    endtask

    task automatic send_dn(input logic [7:0] d_rx, input logic [4:0] e_rx, input bit inj,
                           input bit clr, input logic [7:0] exp_d, input logic exp_p,
                           input logic [23:0] exp_s, input string req);
        @(negedge clk);
        up_in_valid = 1'b1; up_in_data = d_rx; up_in_ecc = e_rx; inj_dn_buf = inj;
        @(negedge clk);
        up_in_valid = 1'b0; inj_dn_buf = 1'b0;
        chk(req, "dn_out_valid", 32'(dn_out_valid), 32'd1);
        chk(req, "dn_out_data", 32'(dn_out_data), 32'(exp_d));
        chk(req, "dn_out_par", 32'(dn_out_par), 32'(exp_p));
        @(negedge clk);
        chk(req, "err_status", 32'(err_status), 32'(exp_s));
        chk(req, "dn drained", 32'(dn_out_valid), 32'd0);
        if (clr) write_sts('1);
    endtask

    task automatic send_up(input logic [7:0] d_rx, input logic p_rx, input bit inj,
                           input bit clr, input logic [7:0] exp_d, input logic [4:0] exp_e,
                           input logic [23:0] exp_s, input string req);
        @(negedge clk);
        dn_in_valid = 1'b1; dn_in_data = d_rx; dn_in_par = p_rx; inj_up_buf = inj;
        @(negedge clk);
        dn_in_valid = 1'b0; inj_up_buf = 1'b0;
        chk(req, "up_out_valid", 32'(up_out_valid), 32'd1);
        chk(req, "up_out_data", 32'(up_out_data), 32'(exp_d));
        chk(req, "up_out_ecc", 32'(up_out_ecc), 32'(exp_e));
        @(negedge clk);
        chk(req, "err_status", 32'(err_status), 32'(exp_s));
        chk(req, "up drained", 32'(up_out_valid), 32'd0);
        if (clr) write_sts('1);
    endtask

    initial begin
        logic [12:0] cw;
        logic [7:0]  w [4];
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state under reset
        chk("R1", "status in reset", 32'(err_status), 32'd0);
        chk("R1", "dn_out_valid in reset", 32'(dn_out_valid), 32'd0);
        chk("R1", "up_out_valid in reset", 32'(up_out_valid), 32'd0);
        chk("R1", "up_in_ready in reset", 32'(up_in_ready), 32'd1);
        chk("R1", "dn_in_ready in reset", 32'(dn_in_ready), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "status after reset", 32'(err_status), 32'd0);

        // R8: clean words downstream
        for (int d = 0; d < 256; d++)
            send_dn(8'(d), ref_ecc(8'(d)), 1'b0, 1'b1, 8'(d), ^8'(d), 24'h0, "R8");

        // R2: every single-bit flip of the code word is corrected
        for (int d = 0; d < 256; d++)
            for (int b = 0; b < 13; b++) begin
                cw = {ref_ecc(8'(d)), 8'(d)} ^ (13'd1 << b);
                send_dn(cw[7:0], cw[12:8], 1'b0, 1'b1, 8'(d), ^8'(d), 24'h0, "R2");
            end

        // R3: every double-bit flip is logged and poisoned
        for (int d = 0; d < 256; d += 17)
            for (int a = 0; a < 13; a++)
                for (int b = a + 1; b < 13; b++) begin
                    cw = {ref_ecc(8'(d)), 8'(d)} ^ (13'd1 << a) ^ (13'd1 << b);
                    send_dn(cw[7:0], cw[12:8], 1'b0, 1'b1, cw[7:0], ~(^cw[7:0]), 24'h000001, "R3");
                end

        // R5: buffer error heading downstream
        for (int d = 0; d < 256; d++)
            send_dn(8'(d), ref_ecc(8'(d)), 1'b1, 1'b1, 8'(d) ^ 8'd1, ~(^(8'(d) ^ 8'd1)),
                    24'hE00002, "R5");

        // R7: buffer error on an already poisoned downstream word
        for (int d = 0; d < 256; d += 17)
            send_dn(8'(d) ^ 8'h24, ref_ecc(8'(d)), 1'b1, 1'b1, 8'(d) ^ 8'h25, ~(^(8'(d) ^ 8'h25)),
                    24'h000001, "R7");

        for (int d = 0; d < 256; d++) begin
            // R8: clean words upstream
            send_up(8'(d), ^8'(d), 1'b0, 1'b1, 8'(d), ref_ecc(8'(d)), 24'h0, "R8");
            // R4: downstream parity error forwarded as forced code
            send_up(8'(d), ~(^8'(d)), 1'b0, 1'b1, 8'(d), ref_ecc(8'(d)) ^ 5'b00011, 24'h000004, "R4");
            // R6: buffer error heading upstream
            send_up(8'(d), ^8'(d), 1'b1, 1'b1, 8'(d) ^ 8'd1, ref_ecc(8'(d) ^ 8'd1) ^ 5'b00011,
                    24'hE00008, "R6");
            // R7: buffer error on an already poisoned upstream word
            send_up(8'(d), ~(^8'(d)), 1'b1, 1'b1, 8'(d) ^ 8'd1, ref_ecc(8'(d) ^ 8'd1) ^ 5'b00011,
                    24'h000004, "R7");
        end

        // R9: sticky flags, write-one-to-clear, zeros ignored
        send_dn(8'h3F, ref_ecc(8'h3C), 1'b0, 1'b0, 8'h3F, ~(^8'h3F), 24'h000001, "R9");
        send_up(8'h5A, ~(^8'h5A), 1'b0, 1'b0, 8'h5A, ref_ecc(8'h5A) ^ 5'b00011, 24'h000005, "R9");
        repeat (3) @(negedge clk);
        chk("R9", "status held", 32'(err_status), 32'h000005);
        write_sts(24'h0);
        chk("R9", "zero write ignored", 32'(err_status), 32'h000005);
        write_sts(24'h000001);
        chk("R9", "bit0 cleared only", 32'(err_status), 32'h000004);
        send_dn(8'h81, ref_ecc(8'h81), 1'b1, 1'b0, 8'h80, ~(^8'h80), 24'hE00006, "R9");
        write_sts(24'hE00000);
        chk("R9", "agent cleared only", 32'(err_status), 32'h000006);
        write_sts('1);
        chk("R9", "all cleared", 32'(err_status), 32'h0);

        // R10: stall, fill, order
        w = '{8'h11, 8'hA2, 8'h7C, 8'hF0};
        @(negedge clk);
        dn_out_ready = 1'b0;
        for (int i = 0; i < 4; i++) begin
            chk("R10", "ready before fill", 32'(up_in_ready), 32'd1);
            up_in_valid = 1'b1; up_in_data = w[i]; up_in_ecc = ref_ecc(w[i]);
            @(negedge clk);
        end
        chk("R10", "ready low when full", 32'(up_in_ready), 32'd0);
        up_in_data = 8'h55; up_in_ecc = ref_ecc(8'h55);
        repeat (2) @(negedge clk);
        chk("R10", "head kept while full", 32'(dn_out_data), 32'(w[0]));
        up_in_valid = 1'b0;
        dn_out_ready = 1'b1;
        for (int i = 0; i < 4; i++) begin
            chk("R10", "order data", 32'(dn_out_data), 32'(w[i]));
            chk("R10", "order parity", 32'(dn_out_par), 32'(^w[i]));
            @(negedge clk);
        end
        chk("R10", "drained", 32'(dn_out_valid), 32'd0);
        chk("R10", "no status from stall", 32'(err_status), 32'd0);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule